// File: doc/BRIEF.md
# Pixel Clock Best-Match Search

This block picks the output clock setting that comes closest to a requested pixel frequency. Each setting is made of a source clock (288 MHz or 336 MHz), an odd pre-divider, and a power-of-two shift from 0 to 7. The effective divisor of a setting is the pre-divider shifted left by the shift amount. A display controller drives the request and a path select (panel or CRT), then pulses `start`.

The engine tests one candidate at a time. For each one it computes the round-to-nearest quotient with a shared restoring divider, forms the absolute distance from the request, and keeps the candidate only when that distance is strictly smaller than the best so far. The order of the search therefore settles ties. When the scan ends, the divider runs once more to produce the exact truncated output frequency of the winner. The chosen codes and that frequency then appear together with a one-cycle `done` pulse.

The result stays on the outputs until the next accepted `start`. A `start` that arrives while a search is running has no effect.

Top module: `pclk_search`

## Requirements
- R1: Candidates are visited with the source outermost (288 MHz before 336 MHz), then the pre-divider in ascending order, then the shift from 0 up to 7. A candidate replaces the best only if its distance is strictly smaller, so on equal distances the one visited first is kept. The best distance starts at all ones.
- R2: On the CRT path (`panel_sel`=0) only pre-dividers 1 and 3 are tried.
- R3: On the panel path (`panel_sel`=1) pre-dividers 1, 3 and 5 are tried.
- R4: Every shift value from 0 to 7 is tried, with the effective divisor equal to pre-divider << shift. `shift_sel` reports the winning shift as a 3-bit binary value.
- R5: A candidate's value is floor((2·F + D) / (2·D)), where F is the source frequency in Hz and D is the effective divisor. `freq_out` reports floor(F / D) for the winner.
- R6: `src_sel` is 0 for 288 MHz and 1 for 336 MHz. `div_sel` is 0, 1 or 2 for a pre-divider of 1, 3 or 5, and never 3.
- R7: A `start` while `busy` is high is ignored, and the running search finishes on its original request.
- R8: `done` is high for exactly one cycle per search, in the cycle when the results first appear, and `busy` is low in that cycle. An accepted `start` raises `busy` on the next cycle.
- R9: After reset, `busy`, `done`, `src_sel`, `div_sel`, `shift_sel` and `freq_out` are all 0.
- R10: While idle, the result outputs hold their values until a new search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| req_freq | input | 32 | Requested frequency in Hz |
| panel_sel | input | 1 | 1 = panel path (pre-divider 5 allowed), 0 = CRT path |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| src_sel | output | 1 | Chosen source: 0 = 288 MHz, 1 = 336 MHz |
| div_sel | output | 2 | Chosen pre-divider code: 0/1/2 for 1/3/5 |
| shift_sel | output | 3 | Chosen shift amount |
| freq_out | output | 32 | Truncated output frequency of the chosen setting |

## Verification
The same request is applied once on each path. This shows whether the pre-divider of 5 is allowed only on the panel path. Requests placed exactly halfway between two candidates, within one source and across the two sources, confirm that the first minimum in visiting order wins. A request of zero and an all-ones request push the search to the smallest and largest divisors, which covers the shift of 7 and the bare source. Requests that exactly match settings from the 336 MHz source, and a second `start` pulsed in mid-search, show that late candidates can win and that the running request is not overwritten.

// File: rtl/pclk_search.sv
module pclk_search #(
  parameter int          FW     = 32,
  parameter int          SHW    = 3,
  parameter logic [31:0] SRC0_HZ = 32'd288_000_000,
  parameter logic [31:0] SRC1_HZ = 32'd336_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FW-1:0]   req_freq,
  input  logic            panel_sel,
  output logic            busy,
  output logic            done,
  output logic            src_sel,
  output logic [1:0]      div_sel,
  output logic [SHW-1:0]  shift_sel,
  output logic [FW-1:0]   freq_out
);
  localparam int CW = $clog2(FW);
  localparam logic [SHW-1:0] SH_LAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DIV, S_EVAL} state_t;
  state_t state;

  logic [FW-1:0]  req_q, best_diff, num, den, quo;
  logic [FW:0]    rem;
  logic [CW-1:0]  cnt;
  logic           panel_q, final_q;
  logic           src_c, best_src;
  logic [1:0]     div_c, best_div;
  logic [SHW-1:0] sh_c, best_sh;

  logic [FW-1:0] cur_f, cur_d, diff;
  logic [FW:0]   rem_sh;
  logic          ge, win;
  logic [1:0]    last_div;

  assign busy     = (state != S_IDLE);
  assign cur_f    = src_c ? FW'(SRC1_HZ) : FW'(SRC0_HZ);
  assign cur_d    = FW'({div_c, 1'b1}) << sh_c;
  assign rem_sh   = {rem[FW-1:0], num[FW-1]};
  assign ge       = rem_sh >= {1'b0, den};
  assign diff     = (quo >= req_q) ? quo - req_q : req_q - quo;
  assign win      = diff < best_diff;
  assign last_div = panel_q ? 2'd2 : 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      done      <= 1'b0;
      src_sel   <= 1'b0;
      div_sel   <= 2'd0;
      shift_sel <= '0;
      freq_out  <= '0;
      req_q     <= '0;
      panel_q   <= 1'b0;
      final_q   <= 1'b0;
      best_diff <= '1;
      best_src  <= 1'b0;
      best_div  <= 2'd0;
      best_sh   <= '0;
      src_c     <= 1'b0;
      div_c     <= 2'd0;
      sh_c      <= '0;
      num       <= '0;
      den       <= '0;
      quo       <= '0;
      rem       <= '0;
      cnt       <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          req_q     <= req_freq;
          panel_q   <= panel_sel;
          final_q   <= 1'b0;
          best_diff <= '1;
          src_c     <= 1'b0;
          div_c     <= 2'd0;
          sh_c      <= '0;
          state     <= S_LOAD;
        end
        S_LOAD: begin
          num   <= final_q ? cur_f : (cur_f << 1) + cur_d;
          den   <= final_q ? cur_d : cur_d << 1;
          rem   <= '0;
          quo   <= '0;
          cnt   <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          num <= num << 1;
          quo <= {quo[FW-2:0], ge};
          rem <= ge ? rem_sh - {1'b0, den} : rem_sh;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(FW - 1)) state <= S_EVAL;
        end
        S_EVAL: begin
          if (final_q) begin
            freq_out  <= quo;
            src_sel   <= best_src;
            div_sel   <= best_div;
            shift_sel <= best_sh;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            if (win) begin
              best_diff <= diff;
              best_src  <= src_c;
              best_div  <= div_c;
              best_sh   <= sh_c;
            end
            state <= S_LOAD;
            if (sh_c != SH_LAST) begin
              sh_c <= sh_c + 1'b1;
            end else if (div_c != last_div) begin
              div_c <= div_c + 1'b1;
              sh_c  <= '0;
            end else if (!src_c) begin
              src_c <= 1'b1;
              div_c <= 2'd0;
              sh_c  <= '0;
            end else begin
              final_q <= 1'b1;
              src_c   <= win ? src_c : best_src;
              div_c   <= win ? div_c : best_div;
              sh_c    <= win ? sh_c  : best_sh;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pclk_search_chk.sv
module pclk_search_chk #(
  parameter int FW  = 32,
  parameter int SHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [1:0]     div_sel,
  input logic [SHW-1:0] shift_sel,
  input logic           src_sel,
  input logic [FW-1:0]  freq_out
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done));
  p_div_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_sel != 2'd3));
  p_freq_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (freq_out != '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> ($stable(freq_out) && $stable(src_sel) &&
                          $stable(div_sel) && $stable(shift_sel)));
endmodule

bind pclk_search pclk_search_chk #(.FW(FW), .SHW(SHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .div_sel(div_sel), .shift_sel(shift_sel), .src_sel(src_sel),
  .freq_out(freq_out)
);

// File: tb/tb_pclk_search.sv
module tb_pclk_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_freq = '0;
  logic        panel_sel = 1'b0;
  logic        busy, done, src_sel;
  logic [1:0]  div_sel;
  logic [2:0]  shift_sel;
  logic [31:0] freq_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pclk_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_freq(req_freq),
    .panel_sel(panel_sel), .busy(busy), .done(done), .src_sel(src_sel),
    .div_sel(div_sel), .shift_sel(shift_sel), .freq_out(freq_out)
  );

  // {req, panel, src, div code, shift, freq}
  localparam int NV = 13;
  localparam logic [70:0] VEC [NV] = '{
    {32'd50_000_000,  1'b0, 1'b0, 2'd1, 3'd1, 32'd48_000_000},  // R2
    {32'd58_000_000,  1'b1, 1'b0, 2'd2, 3'd0, 32'd57_600_000},  // R3
    {32'd58_000_000,  1'b0, 1'b1, 2'd1, 3'd1, 32'd56_000_000},  // R2
    {32'd312_000_000, 1'b0, 1'b0, 2'd0, 3'd0, 32'd288_000_000}, // R1 tie across sources
    {32'd156_000_000, 1'b1, 1'b0, 2'd0, 3'd1, 32'd144_000_000}, // R1 tie
    {32'd0,           1'b0, 1'b0, 2'd1, 3'd7, 32'd750_000},     // R4
    {32'd0,           1'b1, 1'b0, 2'd2, 3'd7, 32'd450_000},     // R4
    {32'hFFFF_FFFF,   1'b0, 1'b1, 2'd0, 3'd0, 32'd336_000_000}, // R5
    {32'd525_000,     1'b1, 1'b1, 2'd2, 3'd7, 32'd525_000},     // R6
    {32'd525_000,     1'b0, 1'b0, 2'd1, 3'd7, 32'd750_000},     // R2
    {32'd10_500_000,  1'b0, 1'b1, 2'd0, 3'd5, 32'd10_500_000},  // R4
    {32'd1_000_000,   1'b1, 1'b1, 2'd2, 3'd6, 32'd1_050_000},   // R3
    {32'd1_000_000,   1'b0, 1'b1, 2'd1, 3'd7, 32'd875_000}      // R2
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] r, input logic p);
    @(negedge clk);
    req_freq  = r;
    panel_sel = p;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); #1;
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic check_result(input string tag, input logic [70:0] v);
    bit ok;
    wait_done(ok);
    check({tag, " done seen"}, 64'(ok), 64'd1);
    check({tag, " R6 codes"}, {58'd0, src_sel, div_sel, shift_sel}, {58'd0, v[37:32]});
    check({tag, " R5 freq"}, 64'(freq_out), 64'(v[31:0]));
    @(posedge clk); #1;
    check({tag, " R8 done one cycle"}, 64'(done), 64'd0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset busy", 64'(busy), 64'd0);
    check("R9 reset done", 64'(done), 64'd0);
    check("R9 reset outputs", {29'd0, src_sel, div_sel, shift_sel, freq_out}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      pulse_start(VEC[k][70:39], VEC[k][38]);
      check_result($sformatf("vec%0d R1", k), VEC[k]);
    end

    // R8: accepted start raises busy
    @(negedge clk);
    req_freq = 32'd58_000_000; panel_sel = 1'b1; start = 1'b1;
    @(posedge clk); #1;
    check("R8 busy after start", 64'(busy), 64'd1);
    @(negedge clk); start = 1'b0;
    // R7: second start mid-search is ignored
    repeat (100) @(negedge clk);
    req_freq = 32'd312_000_000; panel_sel = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check_result("R7 ignored start", VEC[1]);

    // R10: outputs held while idle
    repeat (20) @(posedge clk);
    #1;
    check("R10 hold freq", 64'(freq_out), 64'd57_600_000);
    check("R10 hold codes", {58'd0, src_sel, div_sel, shift_sel}, {58'd0, 1'b0, 2'd2, 3'd0});

    // R9: reset in mid-search clears state
    pulse_start(32'd1_000_000, 1'b1);
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 mid reset busy", 64'(busy), 64'd0);
    check("R9 mid reset outputs", {29'd0, src_sel, div_sel, shift_sel, freq_out}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    pulse_start(32'd10_500_000, 1'b0);
    check_result("R9 after reset", VEC[10]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule